// File: doc/BRIEF.md
# Multicycle accumulator processor sequencer

This block is the control sequencer and register set of a small 8-bit accumulator processor that runs one instruction at a time with no pipelining. It holds a 16-bit program counter and 8-bit accumulator, index, stack-pointer and flag registers. Each instruction walks through opcode fetch, decode, operand fetch, execute and, where needed, write-back. Each state lasts one clock, so every addressing mode has a fixed and known clock count. A one-clock done pulse marks the last clock of every instruction.

Two byte-wide memory ports connect the block to the system. Instruction memory has a 16-bit address, and data memory has an 8-bit address and holds the RAM stack. Both ports are plain, fixed-timing ports and carry no valid/ready handshake. Read data must be valid in the same clock as the address. A write takes effect at the clock edge that ends the cycle in which the write strobe is high. Because there is no back-pressure, no memory may stall the sequencer, and the clock counts below hold exactly.

Opcode byte values: 0x01 add immediate, 0x02 add direct source, 0x03 add indexed source, 0x04 add to direct destination, 0x10 jump, 0x11 jump if carry, 0x12 call, 0x20 push accumulator, 0x21 pop into accumulator, 0x22 pop into index. Jump, jump-if-carry and call carry one operand byte. That byte is a signed offset, added modulo 65536 to the address that follows the instruction. On `flags_o`, bit 1 is zero and bit 0 is carry. The stack grows upward: a push writes at the stack pointer and then increments it.

Top module: `acc_seq_top`

## Requirements
- R1: While reset is low and after its release, before the first instruction completes, the program counter, accumulator, index, stack pointer and flags all read zero, and `instr_done` is low.
- R2: Add immediate (0x01, 2 bytes) takes 4 clocks. The accumulator becomes (A + imm) mod 256, carry is set to the carry out of bit 7, and zero is set when the 8-bit result is 0.
- R3: Add direct (0x02, 2 bytes) takes 6 clocks. It adds the data-memory byte at the operand address to the accumulator, with flags as in R2.
- R4: Add indexed (0x03, 2 bytes) takes 7 clocks. Its source address is (operand + index) mod 256, and flags are set as in R2.
- R5: Add to memory (0x04, 2 bytes) takes 7 clocks. It writes (A + mem[operand]) mod 256 back to that address, leaves the accumulator unchanged and sets flags as in R2. The data port never raises read and write in the same clock.
- R6: Jump (0x10, 2 bytes) takes 5 clocks and loads the program counter with (address after the instruction + sign-extended offset) mod 65536.
- R7: Jump if carry (0x11, 2 bytes) takes 5 clocks whether taken or not. It branches as in R6 only when carry is 1 and otherwise continues at the next instruction. Flags are unchanged.
- R8: Call (0x12, 2 bytes) takes 11 clocks. It writes the return address high byte at SP and the low byte at SP+1, ends with SP increased by 2, jumps as in R6 and leaves the accumulator unchanged.
- R9: Push (0x20) takes 4 clocks and writes A at SP, then increments SP. Pop (0x21 to A, 0x22 to index) takes 4 clocks: it decrements SP, then loads mem[SP]. Pops leave the flags unchanged.
- R10: The stack pointer wraps modulo 256 in both directions.
- R11: Any other opcode takes 2 clocks. It advances the program counter by one and changes no other register and no memory.
- R12: `instr_done` is high for exactly one clock, the last clock of each instruction. The next clock is the fetch of the following instruction, and the count of clocks between done pulses is one of 2, 4, 5, 6, 7 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 16 | Instruction memory byte address (program counter) |
| imem_rdata | input | 8 | Instruction byte at `imem_addr`, same clock |
| dmem_addr | output | 8 | Data memory byte address |
| dmem_re | output | 1 | Data read strobe |
| dmem_we | output | 1 | Data write strobe, write at end of clock |
| dmem_wdata | output | 8 | Data written when `dmem_we` is high |
| dmem_rdata | input | 8 | Data byte at `dmem_addr`, same clock |
| instr_done | output | 1 | High in the last clock of each instruction |
| acc_o | output | 8 | Accumulator |
| x_o | output | 8 | Index register |
| sp_o | output | 8 | Stack pointer |
| flags_o | output | 2 | Bit 1 zero, bit 0 carry |

## Verification
Two functions share one clock in two places. In a stack write, the RAM store must use the old stack pointer while the stack pointer increments in the same clock. In a call, the second push lands one address above the first even when the pointer crosses 0xFF to 0x00. The bench provokes the crossing by popping from reset, so the pointer wraps to 0xFF and then 0xFE, and then issuing a call from a high program address reached by a wrapping jump. It then judges the bench memory model at SP and SP+1 against the computed return-address bytes, and compares the final stack pointer and program counter against values computed in the bench.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [4:0] {
    S_FETCH, S_DECODE, S_OPND, S_IDX, S_MADDR, S_MREAD, S_EXEC, S_WB,
    S_JLO, S_JHI, S_PSETUP, S_PHA, S_PHW, S_PLA, S_PLW, S_CJMP,
    S_PUA, S_PUW, S_SPDEC, S_PRD
  } seq_state_t;

  typedef enum logic [3:0] {
    K_ADDI, K_ADDD, K_ADDX, K_ADDM, K_JMP, K_JC, K_CALL,
    K_PUSH, K_POPA, K_POPX, K_NOP
  } op_kind_t;

  localparam logic [7:0] OP_ADD_IMM = 8'h01;
  localparam logic [7:0] OP_ADD_DIR = 8'h02;
  localparam logic [7:0] OP_ADD_IDX = 8'h03;
  localparam logic [7:0] OP_ADD_MEM = 8'h04;
  localparam logic [7:0] OP_JMP     = 8'h10;
  localparam logic [7:0] OP_JC      = 8'h11;
  localparam logic [7:0] OP_CALL    = 8'h12;
  localparam logic [7:0] OP_PUSH_A  = 8'h20;
  localparam logic [7:0] OP_POP_A   = 8'h21;
  localparam logic [7:0] OP_POP_X   = 8'h22;

endpackage

// File: rtl/acc_seq_add.sv
module acc_seq_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]  = a[i] ^ b[i] ^ c[i];
    assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign cout = c[W];

endmodule

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
  import acc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] op,
  output op_kind_t          kind
);

  always_comb begin
    case (op)
      DATA_W'(OP_ADD_IMM): kind = K_ADDI;
      DATA_W'(OP_ADD_DIR): kind = K_ADDD;
      DATA_W'(OP_ADD_IDX): kind = K_ADDX;
      DATA_W'(OP_ADD_MEM): kind = K_ADDM;
      DATA_W'(OP_JMP):     kind = K_JMP;
      DATA_W'(OP_JC):      kind = K_JC;
      DATA_W'(OP_CALL):    kind = K_CALL;
      DATA_W'(OP_PUSH_A):  kind = K_PUSH;
      DATA_W'(OP_POP_A):   kind = K_POPA;
      DATA_W'(OP_POP_X):   kind = K_POPX;
      default:             kind = K_NOP;
    endcase
  end

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  op_kind_t   kind,
  output seq_state_t st,
  output logic       done
);

  seq_state_t nxt;

  always_comb begin
    nxt = S_FETCH;
    case (st)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (kind)
          K_ADDI, K_ADDD, K_ADDX, K_ADDM,
          K_JMP, K_JC, K_CALL: nxt = S_OPND;
          K_PUSH:              nxt = S_PUA;
          K_POPA, K_POPX:      nxt = S_SPDEC;
          default:             nxt = S_FETCH;
        endcase
      end
      S_OPND: begin
        case (kind)
          K_ADDI:         nxt = S_EXEC;
          K_ADDX:         nxt = S_IDX;
          K_ADDD, K_ADDM: nxt = S_MADDR;
          default:        nxt = S_JLO;
        endcase
      end
      S_IDX:    nxt = S_MADDR;
      S_MADDR:  nxt = S_MREAD;
      S_MREAD:  nxt = S_EXEC;
      S_EXEC:   nxt = (kind == K_ADDM) ? S_WB : S_FETCH;
      S_WB:     nxt = S_FETCH;
      S_JLO:    nxt = S_JHI;
      S_JHI:    nxt = (kind == K_CALL) ? S_PSETUP : S_FETCH;
      S_PSETUP: nxt = S_PHA;
      S_PHA:    nxt = S_PHW;
      S_PHW:    nxt = S_PLA;
      S_PLA:    nxt = S_PLW;
      S_PLW:    nxt = S_CJMP;
      S_CJMP:   nxt = S_FETCH;
      S_PUA:    nxt = S_PUW;
      S_PUW:    nxt = S_FETCH;
      S_SPDEC:  nxt = S_PRD;
      S_PRD:    nxt = S_FETCH;
      default:  nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_FETCH;
    else        st <= nxt;
  end

  assign done = rst_n && (nxt == S_FETCH);

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
  import acc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [2*DATA_W-1:0]   imem_addr,
  input  logic [DATA_W-1:0]     imem_rdata,
  output logic [DATA_W-1:0]     dmem_addr,
  output logic                  dmem_re,
  output logic                  dmem_we,
  output logic [DATA_W-1:0]     dmem_wdata,
  input  logic [DATA_W-1:0]     dmem_rdata,
  output logic                  instr_done,
  output logic [DATA_W-1:0]     acc_o,
  output logic [DATA_W-1:0]     x_o,
  output logic [DATA_W-1:0]     sp_o,
  output logic [1:0]            flags_o
);

  localparam int unsigned PC_W = 2 * DATA_W;

  seq_state_t st;
  op_kind_t   kind;

  logic [PC_W-1:0]   pc_q, tgt_q;
  logic [DATA_W-1:0] acc_q, x_q, sp_q, ir_q, opnd_q, maddr_q, mdata_q;
  logic              c_q, z_q, jcy_q;

  logic [DATA_W-1:0] ex_b, ex_sum, jb_a, jb_b, jb_sum, ix_sum;
  logic              ex_cy, jb_cin, jb_cy, ix_cy;
  logic              take_jump;

  acc_seq_decode #(.DATA_W(DATA_W)) u_dec (
    .op   (ir_q),
    .kind (kind)
  );

  acc_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .kind  (kind),
    .st    (st),
    .done  (instr_done)
  );

  // accumulator adder
  assign ex_b = (kind == K_ADDI) ? opnd_q : mdata_q;
  acc_seq_add #(.W(DATA_W)) u_add_ex (
    .a (acc_q), .b (ex_b), .cin (1'b0), .sum (ex_sum), .cout (ex_cy)
  );

  // branch target adder, low half in S_JLO then high half in S_JHI
  always_comb begin
    if (st == S_JHI) begin
      jb_a   = pc_q[PC_W-1:DATA_W];
      jb_b   = {DATA_W{opnd_q[DATA_W-1]}};
      jb_cin = jcy_q;
    end else begin
      jb_a   = pc_q[DATA_W-1:0];
      jb_b   = opnd_q;
      jb_cin = 1'b0;
    end
  end
  acc_seq_add #(.W(DATA_W)) u_add_jb (
    .a (jb_a), .b (jb_b), .cin (jb_cin), .sum (jb_sum), .cout (jb_cy)
  );

  // index address adder
  acc_seq_add #(.W(DATA_W)) u_add_ix (
    .a (maddr_q), .b (x_q), .cin (1'b0), .sum (ix_sum), .cout (ix_cy)
  );

  assign take_jump = (kind == K_JMP) || ((kind == K_JC) && c_q);

  // memory ports
  assign imem_addr = pc_q;

  always_comb begin
    case (st)
      S_MADDR, S_MREAD, S_WB: dmem_addr = maddr_q;
      default:                dmem_addr = sp_q;
    endcase
    dmem_re = (st == S_MREAD) || (st == S_PRD);
    dmem_we = (st == S_WB) || (st == S_PHW) || (st == S_PLW) || (st == S_PUW);
    case (st)
      S_WB:    dmem_wdata = mdata_q;
      S_PHW:   dmem_wdata = pc_q[PC_W-1:DATA_W];
      S_PLW:   dmem_wdata = pc_q[DATA_W-1:0];
      default: dmem_wdata = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      tgt_q   <= '0;
      acc_q   <= '0;
      x_q     <= '0;
      sp_q    <= '0;
      ir_q    <= '0;
      opnd_q  <= '0;
      maddr_q <= '0;
      mdata_q <= '0;
      c_q     <= 1'b0;
      z_q     <= 1'b0;
      jcy_q   <= 1'b0;
    end else begin
      case (st)
        S_FETCH: begin
          ir_q <= imem_rdata;
          pc_q <= pc_q + 1'b1;
        end
        S_OPND: begin
          opnd_q  <= imem_rdata;
          maddr_q <= imem_rdata;
          pc_q    <= pc_q + 1'b1;
        end
        S_IDX:   maddr_q <= ix_sum;
        S_MREAD: mdata_q <= dmem_rdata;
        S_EXEC: begin
          c_q <= ex_cy;
          z_q <= (ex_sum == '0);
          if (kind == K_ADDM) mdata_q <= ex_sum;
          else                acc_q   <= ex_sum;
        end
        S_JLO: begin
          tgt_q[DATA_W-1:0] <= jb_sum;
          jcy_q             <= jb_cy;
        end
        S_JHI: begin
          tgt_q[PC_W-1:DATA_W] <= jb_sum;
          if (take_jump) pc_q <= {jb_sum, tgt_q[DATA_W-1:0]};
        end
        S_PHW, S_PLW, S_PUW: sp_q <= sp_q + 1'b1;
        S_CJMP:  pc_q <= tgt_q;
        S_SPDEC: sp_q <= sp_q - 1'b1;
        S_PRD: begin
          if (kind == K_POPA) acc_q <= dmem_rdata;
          else                x_q   <= dmem_rdata;
        end
        default: ;
      endcase
    end
  end

  assign acc_o   = acc_q;
  assign x_o     = x_q;
  assign sp_o    = sp_q;
  assign flags_o = {z_q, c_q};

  logic unused_ok;
  assign unused_ok = ix_cy;

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
  import acc_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input seq_state_t st,
  input logic       instr_done,
  input logic       dmem_we,
  input logic       dmem_re,
  input logic [7:0] sp_o,
  input logic [7:0] acc_o,
  input logic [1:0] flags_o
);

  logic [4:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          len_q <= 5'd1;
    else if (instr_done) len_q <= 5'd1;
    else if (len_q != 5'd31) len_q <= len_q + 5'd1;
  end

  assert_len_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> (len_q inside {5'd2, 5'd4, 5'd5, 5'd6, 5'd7, 5'd11}));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);

  assert_fetch_after_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (st == S_FETCH));

  assert_no_rw_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));

  // R9 R10: every stack write is followed by SP+1 mod 256
  assert_stack_write_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_we && (st != S_WB)) |=> (sp_o == 8'($past(sp_o) + 8'd1)));

  assert_call_keeps_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_PHW) || (st == S_PLW) || (st == S_CJMP)) |=> $stable(acc_o));

  assert_pop_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRD) |=> $stable(flags_o));

endmodule

bind acc_seq_top acc_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st         (st),
  .instr_done (instr_done),
  .dmem_we    (dmem_we),
  .dmem_re    (dmem_re),
  .sp_o       (sp_o),
  .acc_o      (acc_o),
  .flags_o    (flags_o)
);

// File: tb/test_acc_seq_top.sv
`timescale 1ns/1ps
module test_acc_seq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr;
  logic [7:0]  imem_rdata;
  logic [7:0]  dmem_addr;
  logic        dmem_re, dmem_we;
  logic [7:0]  dmem_wdata, dmem_rdata;
  logic        instr_done;
  logic [7:0]  acc_o, x_o, sp_o;
  logic [1:0]  flags_o;

  always #2.5 clk = ~clk;

  logic [7:0] imem [0:1023];
  logic [7:0] dmem [0:255];

  assign imem_rdata = imem[imem_addr[9:0]];
  assign dmem_rdata = dmem[dmem_addr];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

  acc_seq_top i_acc_seq_top (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .instr_done(instr_done), .acc_o(acc_o), .x_o(x_o), .sp_o(sp_o),
    .flags_o(flags_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29) + 7);
  endfunction

  function automatic logic [15:0] rel(logic [15:0] base, logic [7:0] off);
    return base + {{8{off[7]}}, off};
  endfunction

  task automatic hold_reset();
    rst_n = 1'b0;
    @(posedge clk); #1;
    for (int i = 0; i < 1024; i++) imem[i] = 8'h00;
    for (int i = 0; i < 256; i++) dmem[i] = pat(i);
  endtask

  task automatic release_reset();
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic step(output int len);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!instr_done && len < 40);
    @(posedge clk); #1;
    chk("R12 done lasts one clock", {31'd0, instr_done}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len;
    logic [8:0] s;
    logic [7:0] a, b, v, xv, d, addr, off;
    logic [15:0] ra, base;

    // R1 reset state
    hold_reset();
    chk("R1 pc", {16'd0, imem_addr}, 0);
    chk("R1 acc", {24'd0, acc_o}, 0);
    chk("R1 x", {24'd0, x_o}, 0);
    chk("R1 sp", {24'd0, sp_o}, 0);
    chk("R1 flags", {30'd0, flags_o}, 0);
    chk("R1 done", {31'd0, instr_done}, 0);
    release_reset();
    @(negedge clk);
    chk("R1 pc after release", {16'd0, imem_addr}, 0);
    chk("R1 done after release", {31'd0, instr_done}, 0);

    // R2 add immediate sweep
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 20; j++) begin
        a = 8'(i * 17); b = 8'(j * 13 + 1);
        hold_reset();
        imem[0] = 8'h01; imem[1] = a; imem[2] = 8'h01; imem[3] = b;
        release_reset();
        step(len);
        chk("R2 len first", len, 4);
        chk("R2 acc first", {24'd0, acc_o}, {24'd0, a});
        chk("R2 flags first", {30'd0, flags_o}, {30'd0, (a == 8'd0), 1'b0});
        step(len);
        s = {1'b0, a} + {1'b0, b};
        chk("R2 len", len, 4);
        chk("R2 acc", {24'd0, acc_o}, {24'd0, s[7:0]});
        chk("R2 flags", {30'd0, flags_o}, {30'd0, (s[7:0] == 8'd0), s[8]});
        chk("R2 pc", {16'd0, imem_addr}, 4);
      end
    end

    // R3 add direct sweep
    for (int i = 0; i < 12; i++) begin
      a = 8'(i * 23 + 200); addr = 8'(i * 21);
      hold_reset();
      imem[0] = 8'h01; imem[1] = a; imem[2] = 8'h02; imem[3] = addr;
      v = dmem[addr];
      release_reset();
      step(len);
      step(len);
      s = {1'b0, a} + {1'b0, v};
      chk("R3 len", len, 6);
      chk("R3 acc", {24'd0, acc_o}, {24'd0, s[7:0]});
      chk("R3 flags", {30'd0, flags_o}, {30'd0, (s[7:0] == 8'd0), s[8]});
    end

    // R4 add indexed sweep (X loaded by a pop that wraps SP, R10)
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        xv = 8'(i * 51 + 1); d = 8'(j * 47 + 250); a = 8'(i + j * 40);
        hold_reset();
        dmem[255] = xv;
        imem[0] = 8'h22; imem[1] = 8'h01; imem[2] = a; imem[3] = 8'h03; imem[4] = d;
        addr = 8'(d + xv);
        v = dmem[addr];
        release_reset();
        step(len);
        chk("R9 pop x len", len, 4);
        chk("R9 pop x value", {24'd0, x_o}, {24'd0, xv});
        chk("R10 sp wrap down", {24'd0, sp_o}, 32'hFF);
        step(len);
        step(len);
        s = {1'b0, a} + {1'b0, v};
        chk("R4 len", len, 7);
        chk("R4 acc", {24'd0, acc_o}, {24'd0, s[7:0]});
        chk("R4 flags", {30'd0, flags_o}, {30'd0, (s[7:0] == 8'd0), s[8]});
      end
    end

    // R5 add to memory sweep
    for (int i = 0; i < 12; i++) begin
      a = 8'(i * 37 + 9); addr = 8'(i * 19 + 3);
      hold_reset();
      imem[0] = 8'h01; imem[1] = a; imem[2] = 8'h04; imem[3] = addr;
      v = dmem[addr];
      release_reset();
      step(len);
      step(len);
      s = {1'b0, a} + {1'b0, v};
      chk("R5 len", len, 7);
      chk("R5 acc unchanged", {24'd0, acc_o}, {24'd0, a});
      chk("R5 mem written", {24'd0, dmem[addr]}, {24'd0, s[7:0]});
      chk("R5 flags", {30'd0, flags_o}, {30'd0, (s[7:0] == 8'd0), s[8]});
    end

    // R6 jump offsets, including backward wrap
    for (int i = 0; i < 16; i++) begin
      off = 8'(i * 17 + 5);
      hold_reset();
      imem[0] = 8'h10; imem[1] = off;
      release_reset();
      step(len);
      chk("R6 len", len, 5);
      chk("R6 target", {16'd0, imem_addr}, {16'd0, rel(16'd2, off)});
    end

    // R7 jump if carry, taken and not taken
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 4; j++) begin
        b = (i == 0) ? 8'd0 : 8'(i * 33 - 32);
        off = 8'(j * 70 + 3);
        hold_reset();
        imem[0] = 8'h01; imem[1] = 8'hFF; imem[2] = 8'h01; imem[3] = b;
        imem[4] = 8'h11; imem[5] = off;
        release_reset();
        step(len); step(len);
        s = 9'h0FF + {1'b0, b};
        step(len);
        chk("R7 len", len, 5);
        chk("R7 pc", {16'd0, imem_addr},
            {16'd0, s[8] ? rel(16'd6, off) : 16'd6});
        chk("R7 flags kept", {30'd0, flags_o}, {30'd0, (s[7:0] == 8'd0), s[8]});
      end
    end

    // R8 call from a high address, with SP crossing 0xFF (R10)
    for (int n = 0; n < 3; n++) begin
      for (int j = 0; j < 3; j++) begin
        off = 8'(j * 100 + 20);
        hold_reset();
        for (int k = 0; k < n; k++) imem[k] = 8'h21;
        imem[n] = 8'h10; imem[n+1] = 8'h80;
        base = rel(16'(n + 2), 8'h80);
        imem[base[9:0]] = 8'h12; imem[base[9:0] + 10'd1] = off;
        for (int k = 0; k < 256; k++) dmem[k] = 8'hAA;
        release_reset();
        for (int k = 0; k < n; k++) step(len);
        chk("R10 sp before call", {24'd0, sp_o}, {24'd0, 8'(256 - n)});
        step(len);
        chk("R6 wrap target", {16'd0, imem_addr}, {16'd0, base});
        a = acc_o;
        step(len);
        ra = base + 16'd2;
        chk("R8 len", len, 11);
        chk("R8 hi byte at sp", {24'd0, dmem[8'(256 - n)]}, {24'd0, ra[15:8]});
        chk("R8 lo byte at sp+1", {24'd0, dmem[8'(257 - n)]}, {24'd0, ra[7:0]});
        chk("R8 sp plus two", {24'd0, sp_o}, {24'd0, 8'(258 - n)});
        chk("R8 target", {16'd0, imem_addr}, {16'd0, rel(ra, off)});
        chk("R8 acc kept", {24'd0, acc_o}, {24'd0, a});
      end
    end

    // R9 push and pop
    for (int i = 0; i < 8; i++) begin
      a = 8'(i * 31 + 2); b = 8'(255 - i * 9);
      hold_reset();
      dmem[255] = 8'h5C;
      imem[0] = 8'h01; imem[1] = a; imem[2] = 8'h20;
      imem[3] = 8'h01; imem[4] = b; imem[5] = 8'h21; imem[6] = 8'h22;
      release_reset();
      step(len);
      step(len);
      chk("R9 push len", len, 4);
      chk("R9 push mem", {24'd0, dmem[0]}, {24'd0, a});
      chk("R9 push sp", {24'd0, sp_o}, 1);
      step(len);
      s = {1'b0, a} + {1'b0, b};
      step(len);
      chk("R9 pop a len", len, 4);
      chk("R9 pop a value", {24'd0, acc_o}, {24'd0, a});
      chk("R9 pop a sp", {24'd0, sp_o}, 0);
      chk("R9 pop flags kept", {30'd0, flags_o}, {30'd0, (s[7:0] == 8'd0), s[8]});
      step(len);
      chk("R9 pop x len", len, 4);
      chk("R9 pop x value", {24'd0, x_o}, 32'h5C);
      chk("R10 sp wrap", {24'd0, sp_o}, 32'hFF);
    end

    // R11 every undefined opcode
    for (int op = 0; op < 256; op++) begin
      if (!(op inside {8'h01, 8'h02, 8'h03, 8'h04, 8'h10, 8'h11, 8'h12,
                       8'h20, 8'h21, 8'h22})) begin
        a = 8'(op + 128);
        hold_reset();
        imem[0] = 8'h01; imem[1] = a; imem[2] = 8'(op);
        release_reset();
        step(len);
        step(len);
        chk("R11 len", len, 2);
        chk("R11 pc", {16'd0, imem_addr}, 3);
        chk("R11 acc", {24'd0, acc_o}, {24'd0, a});
        chk("R11 state", {14'd0, flags_o, sp_o, x_o}, {14'd0, (a == 8'd0), 1'b0, 16'd0});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule